// File: doc/BRIEF.md
# Prescaled Serial Peripheral Master

This block runs one full-duplex serial exchange. It sends a parallel word out on the serial data output and, at the same time, collects a word from the serial data input. The serial clock is made by dividing the interface clock. An 8-bit divide control sets the division. A polarity input sets the level at which the serial clock rests. A phase input sets whether data moves out on the first edge of each bit or half a bit earlier.

A requester presents a word and the three controls, then pulses `start`. The block takes a copy of the controls and runs sixteen serial clock edges. After the last edge it pulses `done` for one cycle, and `rx_word` then holds the received word. A `start` pulse that arrives during an exchange is dropped.

Top module: `spi_master_ps`

## Requirements
- R1: While `rst_n` is low, and whenever no exchange is running, `sclk` equals `cpol`. Reset drives `mosi` low and `done` low.
- R2: If `div` is between 1 and 255, one serial clock period P lasts `div`+1 interface clocks. `done` goes high exactly 8·P clocks after the clock edge that accepts `start`.
- R3: A `div` of 0 gives P = 2, the same as a `div` of 1.
- R4: When P is odd, `sclk` is high for ceil(P/2) clocks of each period and low for floor(P/2) clocks.
- R5: With `cpha` = 0, the first edge of each bit (leading edge, away from the rest level) launches `mosi`, and the trailing edge samples `miso`. With `cpol` = 0 the leading edge is the rising edge; with `cpol` = 1 it is the falling edge.
- R6: With `cpha` = 1, the first bit appears on `mosi` at the edge that accepts `start`. The leading edge samples `miso` and the trailing edge launches the next bit.
- R7: Both words travel most significant bit first. On `done`, bit 7 of `rx_word` holds the first bit sampled and bit 0 holds the last.
- R8: `done` is high for exactly one clock, and in that clock `sclk` is back at its rest level.
- R9: A `start` pulse during an exchange has no effect on the bits, the timing or the received word.
- R10: The block copies `div`, `cpol` and `cpha` when it accepts `start`. Changes to these inputs during the exchange have no effect until the next exchange.
- R11: The first `sclk` edge comes one rest-level half period after the accepting edge. That is ceil(P/2) clocks when `cpol` = 1 and floor(P/2) clocks when `cpol` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin an exchange; accepted only when idle |
| tx_word | input | 8 | Word to send |
| div | input | 8 | Prescale value: period = div+1 clocks, 0 means 2 |
| cpol | input | 1 | Rest level of the serial clock |
| cpha | input | 1 | 0: launch on leading edge; 1: first bit early, sample on leading edge |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| rx_word | output | 8 | Word received, valid from `done` |
| done | output | 1 | One-clock pulse when an exchange ends |

## Verification
The hardest case to reach is a change to the controls, or a second `start` pulse, that lands inside an exchange and also near a launch or sample edge. This is the only way to catch a design that reads the live inputs rather than its copy. The bench reaches it by driving a second `start` with a different word, and flipping polarity, phase and divide all at once, a few clocks after the first edge. It puts the inputs back before the exchange ends. It then checks that the period, the first-edge delay, the bits sent and the word received all match the original settings. A slave model that reacts to the observed `sclk` edges supplies `miso`, so a wrong edge choice shows up as corrupted data.

// File: rtl/spm_pkg.sv
// Package: shared types and the half-period length rule for the serial master.
// Assumes an 8-bit prescale field; the period is never shorter than 2 clocks.
package spm_pkg;

    localparam int SPM_PS_W = 8;

    typedef struct packed {
        logic [SPM_PS_W-1:0] ps;
        logic                cpol;
        logic                cpha;
    } cfg_t;

    // Clocks spent at the given sclk level, minus one, for a prescale value.
    function automatic logic [SPM_PS_W-1:0] half_len_m1(
        input logic [SPM_PS_W-1:0] ps,
        input logic                lvl
    );
        logic [SPM_PS_W:0] per;
        logic [SPM_PS_W:0] h;
        per = (ps == '0) ? (SPM_PS_W+1)'(2) : ({1'b0, ps} + 1'b1);
        h   = lvl ? ((per + 1'b1) >> 1) : (per >> 1);
        return SPM_PS_W'(h - 1'b1);
    endfunction

endpackage

// File: rtl/spm_divider.sv
// Half-period counter. After a load, it pulses tick when the current sclk half has
// run out, then reloads with the length of the following half.
// Assumes load and run are never high together in a way that matters (load wins).
module spm_divider #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    input  logic [CNT_W-1:0] reload_val,
    output logic             tick
);

    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt == '0);

    // Count down through each half period; reload on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run) begin
            cnt <= (cnt == '0) ? reload_val : cnt - 1'b1;
        end
    end

endmodule

// File: rtl/spm_sequencer.sv
// Exchange sequencer. Accepts start when idle, holds a copy of the controls, toggles
// the serial clock on each divider tick, classifies each edge as launch or sample,
// and ends the exchange after 2*WORD_W edges with a one-clock done pulse.
// Assumes tick appears only while busy.
module spm_sequencer #(
    parameter int WORD_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  spm_pkg::cfg_t  cfg_in,
    input  logic           tick,
    output spm_pkg::cfg_t  cfg,
    output logic           busy,
    output logic           accept,
    output logic           sclk_q,
    output logic           launch,
    output logic           sample,
    output logic           last,
    output logic           done
);

    localparam int EDGES = 2 * WORD_W;
    localparam int EC_W  = $clog2(EDGES + 1);

    logic [EC_W-1:0] edge_cnt;
    logic            leading;
    logic            trailing;

    assign accept   = start && !busy;
    assign leading  = tick && (sclk_q == cfg.cpol);
    assign trailing = tick && (sclk_q != cfg.cpol);
    assign last     = tick && (edge_cnt == EC_W'(EDGES - 1));

    // Decide which edges move data out and which capture data in.
    always_comb begin
        if (cfg.cpha) begin
            sample = leading;
            launch = trailing && !last;
        end else begin
            sample = trailing;
            launch = leading;
        end
    end

    // Track the exchange state, the serial clock level and the edge count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            sclk_q   <= 1'b0;
            edge_cnt <= '0;
            done     <= 1'b0;
            cfg      <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy     <= 1'b1;
                cfg      <= cfg_in;
                sclk_q   <= cfg_in.cpol;
                edge_cnt <= '0;
            end else if (tick) begin
                sclk_q <= ~sclk_q;
                if (last) begin
                    busy     <= 1'b0;
                    done     <= 1'b1;
                    edge_cnt <= '0;
                end else begin
                    edge_cnt <= edge_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spm_shifter.sv
// Data path. Shifts the transmit word out MSB first on launch edges and collects
// incoming bits on sample edges. The received word is published on the last edge.
// Assumes the sequencer never asserts launch and sample together.
module spm_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              early_first,
    input  logic              launch,
    input  logic              sample,
    input  logic              last,
    input  logic              miso,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_word
);

    logic [WORD_W-1:0] tx_sr;
    logic [WORD_W-1:0] rx_sr;
    logic [WORD_W-1:0] rx_next;

    assign rx_next = {rx_sr[WORD_W-2:0], miso};

    // Transmit shift: preload the word, drive the head bit early in phase 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
            mosi  <= 1'b0;
        end else if (load) begin
            if (early_first) begin
                mosi  <= tx_word[WORD_W-1];
                tx_sr <= tx_word << 1;
            end else begin
                tx_sr <= tx_word;
            end
        end else if (launch) begin
            mosi  <= tx_sr[WORD_W-1];
            tx_sr <= tx_sr << 1;
        end
    end

    // Receive shift and word hand-off at the final edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sr   <= '0;
            rx_word <= '0;
        end else begin
            if (sample) begin
                rx_sr <= rx_next;
            end
            if (last) begin
                rx_word <= sample ? rx_next : rx_sr;
            end
        end
    end

endmodule

// File: rtl/spi_master_ps.sv
// Top of the prescaled serial master: wires the sequencer, the half-period divider
// and the data shifter. sclk rests at the live polarity input while idle.
// Assumes synchronous active-low reset and a single interface clock.
module spi_master_ps #(
    parameter int WORD_W = 8,
    parameter int PS_W   = spm_pkg::SPM_PS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_word,
    input  logic [PS_W-1:0]   div,
    input  logic              cpol,
    input  logic              cpha,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [WORD_W-1:0] rx_word,
    output logic              done
);

    import spm_pkg::*;

    spm_pkg::cfg_t      cfg_in;
    spm_pkg::cfg_t      cfg;
    logic               busy;
    logic               accept;
    logic               sclk_q;
    logic               launch;
    logic               sample;
    logic               last;
    logic               tick;
    logic [PS_W-1:0]    load_val;
    logic [PS_W-1:0]    reload_val;

    assign cfg_in     = '{ps: div, cpol: cpol, cpha: cpha};
    assign load_val   = half_len_m1(div, cpol);
    assign reload_val = half_len_m1(cfg.ps, ~sclk_q);
    assign sclk       = busy ? sclk_q : cpol;

    spm_sequencer #(.WORD_W(WORD_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .cfg_in (cfg_in),
        .tick   (tick),
        .cfg    (cfg),
        .busy   (busy),
        .accept (accept),
        .sclk_q (sclk_q),
        .launch (launch),
        .sample (sample),
        .last   (last),
        .done   (done)
    );

    spm_divider #(.CNT_W(PS_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_val   (load_val),
        .run        (busy),
        .reload_val (reload_val),
        .tick       (tick)
    );

    spm_shifter #(.WORD_W(WORD_W)) u_shf (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept),
        .tx_word     (tx_word),
        .early_first (cpha),
        .launch      (launch),
        .sample      (sample),
        .last        (last),
        .miso        (miso),
        .mosi        (mosi),
        .rx_word     (rx_word)
    );

endmodule

// File: rtl/spm_checker.sv
// Checker: temporal properties of the serial master, attached by bind.
// Assumes the top's internal busy, tick and cfg nets are visible to the bind.
module spm_checker (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          tick,
    input logic          sclk,
    input logic          mosi,
    input logic          done,
    input spm_pkg::cfg_t cfg
);

    // R8: done lasts a single clock.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: the copied controls do not move during an exchange.
    assert_cfg_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cfg));

    // R2: sclk changes only when the divider expires.
    assert_sclk_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(sclk));

    // R5: mosi changes only on an edge during an exchange.
    assert_mosi_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(mosi));

    // R3: with a prescale of 0 or 1, every busy clock is an edge.
    assert_fast_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cfg.ps <= 8'd1)) |-> tick);

endmodule

bind spi_master_ps spm_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .tick  (tick),
    .sclk  (sclk),
    .mosi  (mosi),
    .done  (done),
    .cfg   (cfg)
);

// File: tb/test_spi_master_ps.sv
// Bench: a vector table walked by one loop, then directed reset and corner tests.
// A slave model reacts to observed sclk edges to supply miso and record mosi.
module test_spi_master_ps;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic [7:0] tx_word;
    logic [7:0] div;
    logic       cpol;
    logic       cpha;
    logic       sclk;
    logic       mosi;
    logic       miso;
    logic [7:0] rx_word;
    logic       done;

    int tests_run = 0;
    int tests_failed = 0;

    // {div, cpol, cpha, tx, slave word}
    localparam logic [25:0] VEC [NVEC] = '{
        {8'd3, 1'b0, 1'b0, 8'hA5, 8'h3C},
        {8'd3, 1'b1, 1'b0, 8'h5A, 8'hC3},
        {8'd3, 1'b0, 1'b1, 8'h81, 8'h7E},
        {8'd3, 1'b1, 1'b1, 8'hF0, 8'h0F},
        {8'd4, 1'b0, 1'b0, 8'h96, 8'h69},
        {8'd4, 1'b1, 1'b1, 8'h1E, 8'hE1},
        {8'd0, 1'b0, 1'b0, 8'hFF, 8'h00},
        {8'd1, 1'b1, 1'b1, 8'h00, 8'hFF},
        {8'd6, 1'b0, 1'b1, 8'hC9, 8'h36}
    };

    spi_master_ps i_spi_master_ps (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tx_word (tx_word),
        .div     (div),
        .cpol    (cpol),
        .cpha    (cpha),
        .sclk    (sclk),
        .mosi    (mosi),
        .miso    (miso),
        .rx_word (rx_word),
        .done    (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One exchange; optional disturbance mid-way (R9, R10).
    task automatic run_xfer(input logic [7:0] ps, input logic pol, input logic pha,
                            input logic [7:0] tx, input logic [7:0] sw, input bit poke);
        int p, li, n, hi, first_n, sidx;
        logic prev_sclk, prev_mosi, lead, samp;
        logic [7:0] got;
        p  = (ps == 0) ? 2 : ps + 1;
        li = pol ? (p + 1) / 2 : p / 2;
        @(negedge clk);
        div = ps; cpol = pol; cpha = pha; tx_word = tx; start = 1'b1;
        sidx = 0;
        miso = pha ? sw[7] : 1'b0;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 0; hi = int'(sclk); first_n = -1; got = '0;
        prev_sclk = sclk; prev_mosi = mosi;
        while (1) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (sclk != prev_sclk) begin
                lead = (sclk != pol);
                if (first_n < 0) first_n = n;
                samp = pha ? lead : !lead;
                if (samp) begin
                    got = {got[6:0], prev_mosi};
                end else if (!pha) begin
                    miso = sw[7 - sidx];
                    sidx++;
                end else begin
                    sidx++;
                    if (sidx < 8) miso = sw[7 - sidx];
                end
            end
            if (done) break;
            if (n > 3000) begin
                check(1'b0, "R2 watchdog", n, 8 * p);
                return;
            end
            hi += int'(sclk);
            if (poke && n == 3) begin
                start = 1'b1; tx_word = ~tx; cpol = ~pol; cpha = ~pha; div = ps + 8'd5;
            end
            if (poke && n == 4) begin
                start = 1'b0; tx_word = tx; cpol = pol; cpha = pha; div = ps;
            end
            prev_sclk = sclk;
            prev_mosi = mosi;
        end
        check(n == 8 * p, (ps == 0) ? "R3 period" : "R2 period", n, 8 * p);
        check(first_n == li, "R11 first edge", first_n, li);
        check(hi == 8 * ((p + 1) / 2), "R4 high time", hi, 8 * ((p + 1) / 2));
        check(got == tx, pha ? "R6 mosi word" : "R5 mosi word", got, tx);
        check(rx_word == sw, "R7 rx word", rx_word, sw);
        check(sclk == pol, "R8 sclk at rest", sclk, pol);
        if (poke) check(got == tx && rx_word == sw, "R9 R10 disturbance ignored", rx_word, sw);
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, "R8 done width", done, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        check(1'b0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; tx_word = '0; div = 8'd3; cpol = 1'b1; cpha = 1'b0;
        miso = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(sclk == 1'b1, "R1 reset sclk pol1", sclk, 1);
        check(mosi == 1'b0, "R1 reset mosi", mosi, 0);
        check(done == 1'b0, "R1 reset done", done, 0);
        cpol = 1'b0;
        @(negedge clk);
        check(sclk == 1'b0, "R1 reset sclk pol0", sclk, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            run_xfer(VEC[i][25:18], VEC[i][17], VEC[i][16], VEC[i][15:8], VEC[i][7:0], 1'b0);
        end

        // R2: longest period
        run_xfer(8'd255, 1'b0, 1'b0, 8'h6B, 8'hD2, 1'b0);
        // R9, R10: start pulse and control changes mid-exchange
        run_xfer(8'd3, 1'b0, 1'b0, 8'h47, 8'hB8, 1'b1);
        run_xfer(8'd2, 1'b1, 1'b1, 8'h2D, 8'h99, 1'b1);
        // R1: idle sclk follows polarity after exchanges
        @(negedge clk);
        cpol = 1'b1;
        @(negedge clk);
        check(sclk == 1'b1, "R1 idle sclk", sclk, 1);

        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule